// File: doc/BRIEF.md
# Triple-Voted I2C Configuration Target

This block is the configuration front end of a multi-channel readout chip. It is an I2C target that answers to a 7-bit geographical address taken from pins on the board. It also answers to a shared broadcast address, so one master transaction can load the same setup into every chip on the line. The configuration bytes reach the chip core as one flat parallel bus. That bus carries the bits with no handshake and holds its value between writes.

Every stored bit is kept in three independent register copies, and the core sees the two-of-three majority of those copies. A write to a register updates all three copies in the same clock cycle. A later write therefore repairs a copy that was upset. The master can read the voted value back at any time, including while the core is acquiring data, and a read changes no stored bit.

The register window is a run of NREG consecutive register numbers that starts at REG_BASE. With the default values this is 0x70 to 0x77, where register 0x70+k drives cfg_out[8k+7:8k]. A register pointer is loaded by the byte that follows a write address byte. The pointer advances by one after each data byte, whether that byte was written or read. SCL is sampled only: the target never holds it low.

Top module: `cfg_i2c_tmr`

## Requirements
- R1: An address byte whose upper seven bits equal geo_addr is acknowledged (SDA pulled low in the ninth clock) for both write (bit 0 = 0) and read (bit 0 = 1); any other non-broadcast address gets no acknowledge.
- R2: A frame START, own address with write, register number, data byte, STOP is acknowledged on every byte and places the data byte on cfg_out[8k+7:8k] for register REG_BASE+k; internally one write strobe of a single cycle is issued per data byte.
- R3: An address byte of 0x00 (broadcast address 7'h00 with write) is acknowledged whatever geo_addr is, and the register and data bytes that follow are stored exactly as for an own-address write.
- R4: An address byte of 0x01 (broadcast address with read) gets no acknowledge, and the target drives no SDA bit for the rest of that frame.
- R5: After a write frame that carries only a register number, a read frame at the own address returns the voted byte of that register, most significant bit first (example: address byte 0xE2 write, register 0x73, data 0x83, then address byte 0xE3 reads back 0x83).
- R6: Each data byte written or read advances the register pointer by one, so consecutive data bytes in one frame address consecutive registers.
- R7: A write to a register number outside REG_BASE..REG_BASE+NREG-1 is acknowledged and leaves cfg_out unchanged; a read of such a register returns 0x00.
- R8: cfg_out carries the bitwise two-of-three majority of the three stored copies, so an upset in any single copy leaves cfg_out unchanged.
- R9: A write updates all three copies in the same cycle, so after a rewrite a fresh upset in a different copy is again masked.
- R10: cfg_out changes only in the cycle that follows a write strobe; address bytes, pointer loads and read frames leave it unchanged.
- R11: While rst_n is low, cfg_out is all zeros and sda_oe is low.
- R12: The target changes sda_oe only while SCL is low, and after an address it does not acknowledge it keeps SDA released until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it must run at least about eight times faster than SCL |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line as seen on the pad |
| sda_i | input | 1 | I2C data line as seen on the pad |
| geo_addr | input | 7 | Geographical address of this chip |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| cfg_out | output | NREG*8 | Voted register contents, register REG_BASE+k in bits [8k+7:8k] |

## Verification
Single write-then-read frames at the own address test the byte order, the acknowledge timing and the read-back path. Foreign addresses and the broadcast address in both directions separate the three kinds of address match. Multi-byte frames that run from the last implemented register past the end of the window show both pointer advance and the ignore rule for register numbers outside the window. A single copy is upset, then the register is rewritten and a different copy is upset. The second upset is masked only if the rewrite really refreshed all three copies, and that is what separates the voting and repair behaviour from storage that merely looks voted.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          COPIES     = 3;
    localparam logic [6:0]  BCAST_ADDR = 7'h00;

    typedef enum logic [3:0] {
        LK_IDLE,
        LK_ADDR,
        LK_ADDR_ACK,
        LK_REG,
        LK_REG_ACK,
        LK_WDATA,
        LK_WDATA_ACK,
        LK_RDATA,
        LK_RDATA_ACK,
        LK_SKIP
    } link_state_e;

    typedef struct packed {
        link_state_e        state;
        logic [BYTE_W-1:0]  shreg;
        logic [2:0]         bitcnt;
        logic [BYTE_W-1:0]  ptr;
        logic               sda_drv;
        logic               rd_mode;
        logic               wr_en;
        logic [BYTE_W-1:0]  wr_idx;
        logic [BYTE_W-1:0]  wr_data;
        logic               scl_p;
        logic               sda_p;
    } link_regs_t;

    localparam link_regs_t LINK_RESET = '{
        state:   LK_IDLE,
        shreg:   '0,
        bitcnt:  '0,
        ptr:     '0,
        sda_drv: 1'b0,
        rd_mode: 1'b0,
        wr_en:   1'b0,
        wr_idx:  '0,
        wr_data: '0,
        scl_p:   1'b1,
        sda_p:   1'b1
    };

endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_i2c_link.sv
module cfg_i2c_link
    import cfg_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [6:0]        geo_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] rd_idx,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_drv
);

    link_regs_t        regs_q;
    link_regs_t        regs_d;

    logic              scl_rise;
    logic              scl_fall;
    logic              start_c;
    logic              stop_c;
    logic [BYTE_W-1:0] byte_in;
    logic              byte_end;
    logic              own_hit;
    logic              bcast_hit;

    // Line events from the synchronized samples
    assign scl_rise = scl_s & ~regs_q.scl_p;
    assign scl_fall = ~scl_s & regs_q.scl_p;
    assign start_c  = scl_s & regs_q.scl_p & regs_q.sda_p & ~sda_s;
    assign stop_c   = scl_s & regs_q.scl_p & ~regs_q.sda_p & sda_s;

    assign byte_in   = {regs_q.shreg[BYTE_W-2:0], sda_s};
    assign byte_end  = scl_rise && (regs_q.bitcnt == 3'd7);
    assign own_hit   = (byte_in[7:1] == geo_addr);
    assign bcast_hit = (byte_in[7:1] == BCAST_ADDR) && !byte_in[0];

    always_comb begin
        regs_d       = regs_q;
        regs_d.wr_en = 1'b0;
        regs_d.scl_p = scl_s;
        regs_d.sda_p = sda_s;

        if (start_c) begin
            regs_d.state   = LK_ADDR;
            regs_d.bitcnt  = '0;
            regs_d.sda_drv = 1'b0;
        end else if (stop_c) begin
            regs_d.state   = LK_IDLE;
            regs_d.sda_drv = 1'b0;
        end else begin
            case (regs_q.state)
                LK_ADDR, LK_REG, LK_WDATA: begin
                    if (scl_rise) begin
                        regs_d.shreg  = byte_in;
                        regs_d.bitcnt = regs_q.bitcnt + 3'd1;
                    end
                    if (byte_end) begin
                        if (regs_q.state == LK_ADDR) begin
                            if (own_hit || bcast_hit) begin
                                regs_d.state   = LK_ADDR_ACK;
                                regs_d.rd_mode = byte_in[0];
                            end else begin
                                regs_d.state = LK_SKIP;
                            end
                        end else if (regs_q.state == LK_REG) begin
                            regs_d.ptr   = byte_in;
                            regs_d.state = LK_REG_ACK;
                        end else begin
                            regs_d.wr_en   = 1'b1;
                            regs_d.wr_idx  = regs_q.ptr;
                            regs_d.wr_data = byte_in;
                            regs_d.ptr     = regs_q.ptr + 8'd1;
                            regs_d.state   = LK_WDATA_ACK;
                        end
                    end
                end

                LK_ADDR_ACK, LK_REG_ACK, LK_WDATA_ACK: begin
                    if (scl_fall) begin
                        if (!regs_q.sda_drv) begin
                            regs_d.sda_drv = 1'b1;
                        end else begin
                            regs_d.bitcnt = '0;
                            if (regs_q.state == LK_ADDR_ACK && regs_q.rd_mode) begin
                                regs_d.state   = LK_RDATA;
                                regs_d.shreg   = rd_data;
                                regs_d.sda_drv = ~rd_data[BYTE_W-1];
                            end else begin
                                regs_d.sda_drv = 1'b0;
                                regs_d.state   = (regs_q.state == LK_ADDR_ACK) ? LK_REG : LK_WDATA;
                            end
                        end
                    end
                end

                LK_RDATA: begin
                    if (scl_fall) begin
                        if (regs_q.bitcnt == 3'd7) begin
                            regs_d.sda_drv = 1'b0;
                            regs_d.bitcnt  = '0;
                            regs_d.ptr     = regs_q.ptr + 8'd1;
                            regs_d.state   = LK_RDATA_ACK;
                        end else begin
                            regs_d.shreg   = {regs_q.shreg[BYTE_W-2:0], 1'b0};
                            regs_d.sda_drv = ~regs_q.shreg[BYTE_W-2];
                            regs_d.bitcnt  = regs_q.bitcnt + 3'd1;
                        end
                    end
                end

                LK_RDATA_ACK: begin
                    if (scl_rise && sda_s) begin
                        regs_d.state = LK_SKIP;
                    end else if (scl_fall) begin
                        regs_d.state   = LK_RDATA;
                        regs_d.shreg   = rd_data;
                        regs_d.sda_drv = ~rd_data[BYTE_W-1];
                    end
                end

                default: begin
                    regs_d.sda_drv = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= LINK_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_idx  = regs_q.ptr;
    assign wr_en   = regs_q.wr_en;
    assign wr_idx  = regs_q.wr_idx;
    assign wr_data = regs_q.wr_data;
    assign sda_drv = regs_q.sda_drv;

endmodule

// File: rtl/cfg_tmr_copy.sv
module cfg_tmr_copy
    import cfg_i2c_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int ROW_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ROW_W-1:0]       wr_row,
    input  logic [BYTE_W-1:0]      wr_byte,
    output logic [NREG*BYTE_W-1:0] bits_o
);

    logic [NREG*BYTE_W-1:0] bits_d;
    logic [NREG*BYTE_W-1:0] bits_q;

    always_comb begin
        bits_d = bits_q;
        for (int r = 0; r < NREG; r++) begin
            if (wr_en && (wr_row == ROW_W'(r))) begin
                bits_d[r*BYTE_W +: BYTE_W] = wr_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign bits_o = bits_q;

endmodule

// File: rtl/cfg_tmr_bank.sv
module cfg_tmr_bank
    import cfg_i2c_pkg::*;
#(
    parameter int               NREG     = 8,
    parameter logic [BYTE_W-1:0] REG_BASE = 8'h70
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [BYTE_W-1:0]      wr_idx,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic [BYTE_W-1:0]      rd_idx,
    output logic [BYTE_W-1:0]      rd_data,
    output logic [NREG*BYTE_W-1:0] voted_o
);

    localparam int NBITS = NREG * BYTE_W;
    localparam int ROW_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int BASE  = int'(REG_BASE);
    localparam int LAST  = BASE + NREG;

    logic                       wr_hit;
    logic                       rd_hit;
    logic [ROW_W-1:0]           wr_row;
    logic [ROW_W-1:0]           rd_row;
    logic [COPIES-1:0][NBITS-1:0] copy_bits;

    // Window decode of the register number
    always_comb begin
        int wr_off;
        int rd_off;
        wr_off = int'(wr_idx) - BASE;
        rd_off = int'(rd_idx) - BASE;
        wr_hit = (int'(wr_idx) >= BASE) && (int'(wr_idx) < LAST);
        rd_hit = (int'(rd_idx) >= BASE) && (int'(rd_idx) < LAST);
        wr_row = wr_off[ROW_W-1:0];
        rd_row = rd_off[ROW_W-1:0];
    end

    // Three identical copies, all written by the same strobe
    generate
        for (genvar c = 0; c < COPIES; c++) begin : g_copy
            cfg_tmr_copy #(
                .NREG  (NREG),
                .ROW_W (ROW_W)
            ) u_copy (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (wr_en && wr_hit),
                .wr_row  (wr_row),
                .wr_byte (wr_data),
                .bits_o  (copy_bits[c])
            );
        end
    endgenerate

    // Two-of-three majority per bit
    assign voted_o = (copy_bits[0] & copy_bits[1])
                   | (copy_bits[0] & copy_bits[2])
                   | (copy_bits[1] & copy_bits[2]);

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NREG; r++) begin
            if (rd_hit && (rd_row == ROW_W'(r))) begin
                rd_data = voted_o[r*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/cfg_i2c_tmr.sv
module cfg_i2c_tmr
    import cfg_i2c_pkg::*;
#(
    parameter int                NREG     = 8,
    parameter logic [BYTE_W-1:0] REG_BASE = 8'h70,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic [6:0]             geo_addr,
    output logic                   sda_oe,
    output logic [NREG*BYTE_W-1:0] cfg_out
);

    logic [1:0]        line_s;
    logic              link_wr_en;
    logic [BYTE_W-1:0] link_wr_idx;
    logic [BYTE_W-1:0] link_wr_data;
    logic [BYTE_W-1:0] link_rd_idx;
    logic [BYTE_W-1:0] bank_rd_data;

    cfg_i2c_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (line_s)
    );

    cfg_i2c_link u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (line_s[1]),
        .sda_s    (line_s[0]),
        .geo_addr (geo_addr),
        .rd_data  (bank_rd_data),
        .rd_idx   (link_rd_idx),
        .wr_en    (link_wr_en),
        .wr_idx   (link_wr_idx),
        .wr_data  (link_wr_data),
        .sda_drv  (sda_oe)
    );

    cfg_tmr_bank #(
        .NREG     (NREG),
        .REG_BASE (REG_BASE)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (link_wr_en),
        .wr_idx  (link_wr_idx),
        .wr_data (link_wr_data),
        .rd_idx  (link_rd_idx),
        .rd_data (bank_rd_data),
        .voted_o (cfg_out)
    );

endmodule

// File: rtl/cfg_i2c_tmr_chk.sv
module cfg_i2c_tmr_chk #(
    parameter int         NREG     = 8,
    parameter logic [7:0] REG_BASE = 8'h70
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_i,
    input logic            sda_oe,
    input logic [NREG*8-1:0] cfg_out,
    input logic            link_wr_en,
    input logic [7:0]      link_wr_idx
);

    localparam int BASE = int'(REG_BASE);
    localparam int LAST = BASE + NREG;

    logic in_window;
    assign in_window = (int'(link_wr_idx) >= BASE) && (int'(link_wr_idx) < LAST);

    assert_reset_state_R11: assert property (@(posedge clk)
        !rst_n |-> (!sda_oe && (cfg_out == '0)));

    assert_cfg_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !link_wr_en |=> $stable(cfg_out));

    assert_outside_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_wr_en && !in_window) |=> $stable(cfg_out));

    assert_sda_only_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        link_wr_en |=> !link_wr_en);

endmodule

bind cfg_i2c_tmr cfg_i2c_tmr_chk #(
    .NREG     (NREG),
    .REG_BASE (REG_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_oe      (sda_oe),
    .cfg_out     (cfg_out),
    .link_wr_en  (link_wr_en),
    .link_wr_idx (link_wr_idx)
);

// File: tb/sim_cfg_i2c_tmr.sv
`timescale 1ns/1ps
module sim_cfg_i2c_tmr;

    localparam int NREG = 8;
    localparam int Q    = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl = 1'b1;
    logic            m_low = 1'b0;
    logic            sda;
    logic            sda_oe;
    logic [6:0]      geo = 7'h71;
    logic [NREG*8-1:0] cfg_out;
    logic [NREG*8-1:0] exp_cfg = '0;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    assign sda = !(m_low || sda_oe);

    cfg_i2c_tmr u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda),
        .geo_addr (geo),
        .sda_oe   (sda_oe),
        .cfg_out  (cfg_out)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_low = 1'b0; scl = 1'b1; qw(Q);
        m_low = 1'b1; qw(Q);
        scl = 1'b0; qw(Q);
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; qw(Q);
        scl = 1'b1; qw(Q);
        m_low = 1'b0; qw(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = !b[i]; qw(Q);
            scl = 1'b1; qw(2*Q);
            scl = 1'b0; qw(Q);
        end
        m_low = 1'b0; qw(Q);
        scl = 1'b1; qw(Q);
        ack = !sda; qw(Q);
        scl = 1'b0; qw(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_low = 1'b0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            qw(Q);
            scl = 1'b1; qw(Q);
            b = {b[6:0], sda}; qw(Q);
            scl = 1'b0;
        end
        qw(Q);
        m_low = give_ack; qw(Q);
        scl = 1'b1; qw(2*Q);
        scl = 1'b0; qw(Q);
        m_low = 1'b0;
    endtask

    function automatic void model_wr(input logic [7:0] r, input logic [7:0] d);
        if (r >= 8'h70 && r < 8'h78) exp_cfg[(r - 8'h70)*8 +: 8] = d;
    endfunction

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] r, input logic [7:0] d, input string req);
        logic k0, k1, k2;
        i2c_start();
        send_byte(a, k0);
        send_byte(r, k1);
        send_byte(d, k2);
        i2c_stop();
        chk(k0 && k1 && k2, req, {61'd0, k0, k1, k2}, 64'd7);
    endtask

    task automatic set_ptr(input logic [7:0] r);
        logic k0, k1;
        i2c_start();
        send_byte(8'hE2, k0);
        send_byte(r, k1);
        i2c_stop();
        chk(k0 && k1, "R5 pointer frame ack", {62'd0, k0, k1}, 64'd3);
    endtask

    task automatic t_reset();
        chk(cfg_out == '0, "R11 cfg_out after reset", cfg_out, 64'd0);
        chk(sda_oe == 1'b0, "R11 sda released after reset", {63'd0, sda_oe}, 64'd0);
    endtask

    task automatic t_write_read();
        logic k;
        logic [7:0] b;
        wr_reg(8'hE2, 8'h73, 8'h83, "R1 R2 own write acks");
        model_wr(8'h73, 8'h83);
        chk(cfg_out[31:24] == 8'h83, "R2 reg 0x73 on cfg_out", {56'd0, cfg_out[31:24]}, 64'h83);
        set_ptr(8'h73);
        i2c_start();
        send_byte(8'hE3, k);
        chk(k, "R1 own read address ack", {63'd0, k}, 64'd1);
        recv_byte(1'b0, b);
        i2c_stop();
        chk(b == 8'h83, "R5 read back 0x73", {56'd0, b}, 64'h83);
        chk(cfg_out == exp_cfg, "R10 read leaves cfg", cfg_out, exp_cfg);
    endtask

    task automatic t_foreign();
        logic k0, k1, k2;
        i2c_start();
        send_byte(8'hA0, k0);
        send_byte(8'h74, k1);
        send_byte(8'h3C, k2);
        i2c_stop();
        chk(!k0, "R1 foreign address no ack", {63'd0, k0}, 64'd0);
        chk(!k1 && !k2, "R12 silent after nack", {62'd0, k1, k2}, 64'd0);
        chk(cfg_out == exp_cfg, "R12 foreign write ignored", cfg_out, exp_cfg);
    endtask

    task automatic t_bcast();
        logic k0, k1;
        geo = 7'h33;
        wr_reg(8'h00, 8'h70, 8'h5A, "R3 broadcast write acks");
        model_wr(8'h70, 8'h5A);
        chk(cfg_out == exp_cfg, "R3 broadcast stored", cfg_out, exp_cfg);
        i2c_start();
        send_byte(8'h01, k0);
        send_byte(8'hFF, k1);
        i2c_stop();
        chk(!k0 && !k1, "R4 broadcast read no ack", {62'd0, k0, k1}, 64'd0);
        geo = 7'h71;
    endtask

    task automatic t_burst();
        logic k0, k1, k2, k3, k4;
        logic [7:0] b0, b1;
        i2c_start();
        send_byte(8'hE2, k0);
        send_byte(8'h75, k1);
        send_byte(8'h11, k2);
        send_byte(8'h22, k3);
        i2c_stop();
        model_wr(8'h75, 8'h11);
        model_wr(8'h76, 8'h22);
        chk(k0 && k1 && k2 && k3, "R6 burst write acks", {60'd0, k0, k1, k2, k3}, 64'hF);
        chk(cfg_out == exp_cfg, "R6 burst write regs", cfg_out, exp_cfg);
        set_ptr(8'h75);
        i2c_start();
        send_byte(8'hE3, k4);
        recv_byte(1'b1, b0);
        recv_byte(1'b0, b1);
        i2c_stop();
        chk({b0, b1} == 16'h1122, "R6 burst read", {48'd0, b0, b1}, 64'h1122);
        chk(cfg_out == exp_cfg, "R10 burst read leaves cfg", cfg_out, exp_cfg);
    endtask

    task automatic t_outside();
        logic k0, k1, k2, k3, k4;
        logic [7:0] b0, b1;
        wr_reg(8'hE2, 8'h10, 8'hFF, "R7 outside write acks");
        chk(cfg_out == exp_cfg, "R7 outside write ignored", cfg_out, exp_cfg);
        i2c_start();
        send_byte(8'hE2, k0);
        send_byte(8'h77, k1);
        send_byte(8'h6C, k2);
        send_byte(8'hEE, k3);
        i2c_stop();
        model_wr(8'h77, 8'h6C);
        chk(k0 && k1 && k2 && k3, "R7 wrap burst acks", {60'd0, k0, k1, k2, k3}, 64'hF);
        chk(cfg_out == exp_cfg, "R7 byte past window ignored", cfg_out, exp_cfg);
        set_ptr(8'h77);
        i2c_start();
        send_byte(8'hE3, k4);
        recv_byte(1'b1, b0);
        recv_byte(1'b0, b1);
        i2c_stop();
        chk({b0, b1} == 16'h6C00, "R7 read past window is zero", {48'd0, b0, b1}, 64'h6C00);
    endtask

    task automatic t_vote();
        wr_reg(8'hE2, 8'h70, 8'hA5, "R9 write before upset");
        model_wr(8'h70, 8'hA5);
        force u0.u_bank.g_copy[0].u_copy.bits_q = exp_cfg ^ 64'h1;
        qw(4);
        chk(cfg_out == exp_cfg, "R8 single upset masked", cfg_out, exp_cfg);
        release u0.u_bank.g_copy[0].u_copy.bits_q;
        qw(4);
        chk(cfg_out == exp_cfg, "R8 upset kept after release", cfg_out, exp_cfg);
        wr_reg(8'hE2, 8'h70, 8'hA5, "R9 repair write acks");
        force u0.u_bank.g_copy[1].u_copy.bits_q = exp_cfg ^ 64'h1;
        qw(4);
        chk(cfg_out == exp_cfg, "R9 rewrite repaired copy", cfg_out, exp_cfg);
        release u0.u_bank.g_copy[1].u_copy.bits_q;
        wr_reg(8'hE2, 8'h70, 8'hA5, "R9 final repair acks");
        chk(cfg_out == exp_cfg, "R9 final state", cfg_out, exp_cfg);
    endtask

    initial begin
        qw(5);
        t_reset();
        rst_n = 1'b1;
        qw(5);
        t_write_read();
        t_foreign();
        t_bcast();
        t_burst();
        t_outside();
        t_vote();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule